// File: doc/BRIEF.md
# Interrupt Pin Controller

This block turns event requests from a set of detection engines into one physical interrupt output and a readable pending flag. Each request carries an engine identifier and a direction code. Both are gathered into two sticky source registers that software reads to find the cause. A single four-bit control field sets how the pin behaves. It can hold its level until software acknowledges the event, or emit a fixed-length pulse. It can be active-high or active-low, and it can be shut off from the pin entirely. In the alternate setting, the pin follows a motion-active level directly.

Software acknowledges an interrupt with a release-read strobe. In one cycle this clears the pending flag, both source registers and a running pulse. An event that arrives in the same cycle as the release is kept, so no request is lost. The pulse width is a parameter, counted in system clocks.

Control field encoding, with bit 0 as the least significant bit:
- bit 0: alternate motion mode
- bit 1: pulse mode
- bit 2: polarity, where 1 means active-high
- bit 3: pin enable

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset the pending flag and both source outputs are zero, no pulse is running, and the pin rests at its idle level for the applied control value (high when bit 2 is 0).
- R2: A cycle with `evt_valid_i` high sets the pending flag at the next clock edge and ORs `evt_src_i` and `evt_dir_i` into the captured source outputs.
- R3: A release strobe without an event clears the pending flag, both source outputs and any running pulse at the next edge. A release in the same cycle as an event leaves the flag set and the source outputs holding only the new event.
- R4: In latched mode (bit 1 = 0) the pin is active whenever the pending flag is set, and it stays active until a release.
- R5: In pulse mode (bit 1 = 1) the pin is active for exactly PULSE_CYC clock cycles after the event edge and then returns to idle, while the pending flag stays set.
- R6: An event during a running pulse restarts the count, so the pin stays active for PULSE_CYC cycles after the latest event.
- R7: With bit 2 = 1 the pin is active-high and idles low. With bit 2 = 0 it is active-low and idles high.
- R8: With bit 3 = 0 the pin stays at its idle level, but the pending flag and the source outputs still capture events.
- R9: With bit 0 = 1 and `motion_en_i` high, the pin is active in every cycle that `motion_act_i` is high, whatever bit 1 says. Without both of these, `motion_act_i` does not affect the pin.
- R10: While `evt_valid_i` is low, the values on `evt_src_i` and `evt_dir_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_i | input | 4 | Pin behaviour field (alternate, pulse, polarity, enable) |
| evt_valid_i | input | 1 | Event request strobe from a detection engine |
| evt_src_i | input | SRC_W | One-hot identifier of the requesting engine |
| evt_dir_i | input | DIR_W | Direction code carried with the request |
| motion_en_i | input | 1 | Motion detection is enabled |
| motion_act_i | input | 1 | Motion currently active (level) |
| rel_rd_i | input | 1 | Release-read strobe from the register interface |
| int_pin_o | output | 1 | Physical interrupt pin level |
| int_stat_o | output | 1 | Pending interrupt status flag |
| src_eng_o | output | SRC_W | Captured engine identifiers |
| src_dir_o | output | DIR_W | Captured direction codes |

## Verification
Two pairs of functions can land in the same cycle. A release read can coincide with a new event request. A pulse retrigger can arrive while an earlier pulse is still counting. The vector table sets up both cases on purpose. It drives `rel_rd_i` and `evt_valid_i` together and then checks that the flag stays set and that the source outputs hold only the new identifier and direction. It also raises a second event two cycles into a pulse and then samples the pin in the cycle where the first pulse would have ended; the pin must still be active there, and it must drop exactly PULSE_CYC cycles after the second event.

// File: rtl/irq_pin_pkg.sv
// Package: shared control-field type for the interrupt pin controller.
// Assumes the control field is exactly four bits, with bit 0 as the LSB.
package irq_pin_pkg;
    typedef struct packed {
        logic en;     // bit 3: drive events onto the pin
        logic pol;    // bit 2: 1 = active-high
        logic pulse;  // bit 1: 1 = pulse mode, 0 = latched
        logic alt;    // bit 0: pin follows motion level
    } irq_ctrl_t;
endpackage

// File: rtl/irq_src_capture.sv
// Module: holds the pending flag and the two sticky source registers.
// Assumes the release strobe lasts one cycle per read. An event that
// coincides with a release is kept as the only content.
module irq_src_capture #(
    parameter int SRC_W = 4,
    parameter int DIR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid_i,
    input  logic [SRC_W-1:0] evt_src_i,
    input  logic [DIR_W-1:0] evt_dir_i,
    input  logic             rel_rd_i,
    output logic             stat_o,
    output logic [SRC_W-1:0] src_o,
    output logic [DIR_W-1:0] dir_o
);
    // Update the pending flag and the OR-accumulated source flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_o <= 1'b0;
            src_o  <= '0;
            dir_o  <= '0;
        end else if (rel_rd_i) begin
            stat_o <= evt_valid_i;
            src_o  <= evt_valid_i ? evt_src_i : '0;
            dir_o  <= evt_valid_i ? evt_dir_i : '0;
        end else if (evt_valid_i) begin
            stat_o <= 1'b1;
            src_o  <= src_o | evt_src_i;
            dir_o  <= dir_o | evt_dir_i;
        end
    end
endmodule

// File: rtl/irq_pulse_timer.sv
// Module: down-counter that keeps the pulse active for PULSE_CYC clocks.
// Assumes PULSE_CYC >= 1. Each event reloads the count; a release
// without an event cancels the pulse.
module irq_pulse_timer #(
    parameter int PULSE_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic cancel_i,
    output logic active_o
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);

    logic [CNT_W-1:0] cnt_q;

    // Reload on trigger, clear on cancel, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (trig_i)
            cnt_q <= LOAD;
        else if (cancel_i)
            cnt_q <= '0;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // The pulse is active while the count is nonzero.
    always_comb active_o = (cnt_q != '0);
endmodule

// File: rtl/irq_pin_drive.sv
// Module: picks the active source for the pin, then applies enable and
// polarity. Purely combinational; the control bits take effect at once.
module irq_pin_drive
    import irq_pin_pkg::*;
(
    input  irq_ctrl_t ctrl_i,
    input  logic      stat_i,
    input  logic      pulse_act_i,
    input  logic      motion_en_i,
    input  logic      motion_act_i,
    output logic      pin_o
);
    logic base_act;
    logic motion_path;
    logic act;

    // Choose the latched or pulsed view, then OR in the motion level.
    always_comb begin
        base_act    = ctrl_i.pulse ? pulse_act_i : stat_i;
        motion_path = ctrl_i.alt & motion_en_i & motion_act_i;
        act         = base_act | motion_path;
    end

    // Map the active state onto the pin level with enable and polarity.
    always_comb begin
        if (!ctrl_i.en)
            pin_o = ~ctrl_i.pol;
        else
            pin_o = ctrl_i.pol ? act : ~act;
    end
endmodule

// File: rtl/irq_pin_ctrl.sv
// Module: top of the interrupt pin controller. It connects source
// capture, the pulse timer and the pin driver. Assumes a synchronous
// active-low reset and single-cycle event and release strobes.
module irq_pin_ctrl
    import irq_pin_pkg::*;
#(
    parameter int SRC_W     = 4,
    parameter int DIR_W     = 6,
    parameter int PULSE_CYC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ctrl_i,
    input  logic             evt_valid_i,
    input  logic [SRC_W-1:0] evt_src_i,
    input  logic [DIR_W-1:0] evt_dir_i,
    input  logic             motion_en_i,
    input  logic             motion_act_i,
    input  logic             rel_rd_i,
    output logic             int_pin_o,
    output logic             int_stat_o,
    output logic [SRC_W-1:0] src_eng_o,
    output logic [DIR_W-1:0] src_dir_o
);
    irq_ctrl_t ctrl;
    logic      pulse_act;

    // Reinterpret the raw field as the packed control struct.
    always_comb ctrl = irq_ctrl_t'(ctrl_i);

    irq_src_capture #(.SRC_W(SRC_W), .DIR_W(DIR_W)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_valid_i (evt_valid_i),
        .evt_src_i   (evt_src_i),
        .evt_dir_i   (evt_dir_i),
        .rel_rd_i    (rel_rd_i),
        .stat_o      (int_stat_o),
        .src_o       (src_eng_o),
        .dir_o       (src_dir_o)
    );

    irq_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (evt_valid_i),
        .cancel_i (rel_rd_i),
        .active_o (pulse_act)
    );

    irq_pin_drive u_drv (
        .ctrl_i       (ctrl),
        .stat_i       (int_stat_o),
        .pulse_act_i  (pulse_act),
        .motion_en_i  (motion_en_i),
        .motion_act_i (motion_act_i),
        .pin_o        (int_pin_o)
    );
endmodule

// File: rtl/irq_pin_ctrl_chk.sv
// Checker: port-level properties of the interrupt pin controller.
module irq_pin_ctrl_chk #(
    parameter int SRC_W = 4,
    parameter int DIR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       ctrl_i,
    input logic             evt_valid_i,
    input logic [SRC_W-1:0] evt_src_i,
    input logic [DIR_W-1:0] evt_dir_i,
    input logic             motion_en_i,
    input logic             motion_act_i,
    input logic             rel_rd_i,
    input logic             int_pin_o,
    input logic             int_stat_o,
    input logic [SRC_W-1:0] src_eng_o,
    input logic [DIR_W-1:0] src_dir_o
);
    // R2
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_i |=> int_stat_o);

    // R2
    src_accum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && !rel_rd_i) |=>
            ((src_eng_o & $past(evt_src_i)) == $past(evt_src_i)));

    // R3
    release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_rd_i && !evt_valid_i) |=>
            (!int_stat_o && src_eng_o == '0 && src_dir_o == '0));

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_valid_i && !rel_rd_i) |=>
            ($stable(src_eng_o) && $stable(src_dir_o) && $stable(int_stat_o)));

    // R4
    latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i[3] && !ctrl_i[1] && int_stat_o) |-> (int_pin_o == ctrl_i[2]));

    // R8
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i[3] |-> (int_pin_o != ctrl_i[2]));

    // R9
    motion_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i[3] && ctrl_i[0] && motion_en_i && motion_act_i) |->
            (int_pin_o == ctrl_i[2]));
endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk #(.SRC_W(SRC_W), .DIR_W(DIR_W)) u_chk (.*);

// File: tb/irq_pin_ctrl_tb.sv
`timescale 1ns/1ps
module irq_pin_ctrl_tb;
    localparam int SRC_W = 4;
    localparam int DIR_W = 6;
    localparam int PW    = 4;

    typedef struct packed {
        logic [3:0]       ctrl;
        logic             ev;
        logic [SRC_W-1:0] src;
        logic [DIR_W-1:0] dir;
        logic             men;
        logic             mact;
        logic             rel;
        logic             e_pin;
        logic             e_stat;
        logic [SRC_W-1:0] e_src;
        logic [DIR_W-1:0] e_dir;
        logic [3:0]       req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        '{4'hC,1'b1,4'h1,6'h01,1'b0,1'b0,1'b0, 1'b1,1'b1,4'h1,6'h01, 4'd2},  // R2 R4
        '{4'hC,1'b1,4'h2,6'h04,1'b0,1'b0,1'b0, 1'b1,1'b1,4'h3,6'h05, 4'd2},  // R2 OR
        '{4'hC,1'b0,4'hF,6'h3F,1'b0,1'b0,1'b0, 1'b1,1'b1,4'h3,6'h05, 4'd10}, // R10
        '{4'hC,1'b0,4'h0,6'h00,1'b0,1'b0,1'b1, 1'b0,1'b0,4'h0,6'h00, 4'd3},  // R3
        '{4'hC,1'b1,4'h4,6'h10,1'b0,1'b0,1'b1, 1'b1,1'b1,4'h4,6'h10, 4'd3},  // R3 same cycle
        '{4'hC,1'b0,4'h0,6'h00,1'b0,1'b0,1'b1, 1'b0,1'b0,4'h0,6'h00, 4'd3},
        '{4'h8,1'b1,4'h1,6'h02,1'b0,1'b0,1'b0, 1'b0,1'b1,4'h1,6'h02, 4'd7},  // R7 low
        '{4'h8,1'b0,4'h0,6'h00,1'b0,1'b0,1'b1, 1'b1,1'b0,4'h0,6'h00, 4'd7},
        '{4'h4,1'b1,4'h8,6'h20,1'b0,1'b0,1'b0, 1'b0,1'b1,4'h8,6'h20, 4'd8},  // R8
        '{4'h0,1'b0,4'h0,6'h00,1'b0,1'b0,1'b0, 1'b1,1'b1,4'h8,6'h20, 4'd8},
        '{4'h4,1'b0,4'h0,6'h00,1'b0,1'b0,1'b1, 1'b0,1'b0,4'h0,6'h00, 4'd3},
        '{4'hE,1'b1,4'h1,6'h01,1'b0,1'b0,1'b0, 1'b1,1'b1,4'h1,6'h01, 4'd5},  // R5
        '{4'hE,1'b0,4'h0,6'h00,1'b0,1'b0,1'b0, 1'b1,1'b1,4'h1,6'h01, 4'd5},
        '{4'hE,1'b0,4'h0,6'h00,1'b0,1'b0,1'b0, 1'b1,1'b1,4'h1,6'h01, 4'd5},
        '{4'hE,1'b0,4'h0,6'h00,1'b0,1'b0,1'b0, 1'b1,1'b1,4'h1,6'h01, 4'd5},
        '{4'hE,1'b0,4'h0,6'h00,1'b0,1'b0,1'b0, 1'b0,1'b1,4'h1,6'h01, 4'd5},
        '{4'hE,1'b1,4'h2,6'h02,1'b0,1'b0,1'b0, 1'b1,1'b1,4'h3,6'h03, 4'd6},  // R6
        '{4'hE,1'b0,4'h0,6'h00,1'b0,1'b0,1'b0, 1'b1,1'b1,4'h3,6'h03, 4'd6},
        '{4'hE,1'b1,4'h2,6'h02,1'b0,1'b0,1'b0, 1'b1,1'b1,4'h3,6'h03, 4'd6},
        '{4'hE,1'b0,4'h0,6'h00,1'b0,1'b0,1'b0, 1'b1,1'b1,4'h3,6'h03, 4'd6},
        '{4'hE,1'b0,4'h0,6'h00,1'b0,1'b0,1'b0, 1'b1,1'b1,4'h3,6'h03, 4'd6},
        '{4'hE,1'b0,4'h0,6'h00,1'b0,1'b0,1'b0, 1'b1,1'b1,4'h3,6'h03, 4'd6},
        '{4'hE,1'b0,4'h0,6'h00,1'b0,1'b0,1'b0, 1'b0,1'b1,4'h3,6'h03, 4'd6},
        '{4'hE,1'b0,4'h0,6'h00,1'b0,1'b0,1'b1, 1'b0,1'b0,4'h0,6'h00, 4'd3},
        '{4'hD,1'b0,4'h0,6'h00,1'b1,1'b1,1'b0, 1'b1,1'b0,4'h0,6'h00, 4'd9},  // R9
        '{4'hD,1'b0,4'h0,6'h00,1'b1,1'b0,1'b0, 1'b0,1'b0,4'h0,6'h00, 4'd9},
        '{4'hC,1'b0,4'h0,6'h00,1'b1,1'b1,1'b0, 1'b0,1'b0,4'h0,6'h00, 4'd9},
        '{4'hD,1'b0,4'h0,6'h00,1'b0,1'b1,1'b0, 1'b0,1'b0,4'h0,6'h00, 4'd9},
        '{4'hF,1'b0,4'h0,6'h00,1'b1,1'b1,1'b0, 1'b1,1'b0,4'h0,6'h00, 4'd9},
        '{4'h9,1'b0,4'h0,6'h00,1'b1,1'b1,1'b0, 1'b0,1'b0,4'h0,6'h00, 4'd9}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       ctrl_i = 4'h0;
    logic             evt_valid_i = 1'b0;
    logic [SRC_W-1:0] evt_src_i = '0;
    logic [DIR_W-1:0] evt_dir_i = '0;
    logic             motion_en_i = 1'b0;
    logic             motion_act_i = 1'b0;
    logic             rel_rd_i = 1'b0;
    logic             int_pin_o;
    logic             int_stat_o;
    logic [SRC_W-1:0] src_eng_o;
    logic [DIR_W-1:0] src_dir_o;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    irq_pin_ctrl #(.SRC_W(SRC_W), .DIR_W(DIR_W), .PULSE_CYC(PW)) u_dut (.*);

    task automatic check(input string tag, input int row, input logic [31:0] got,
                         input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s row %0d: got %0h expected %0h", tag, row, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #100000;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state with active-low idle (pin high)
        tick(); tick();
        check("R1 pin", -1, 32'(int_pin_o), 32'd1);
        check("R1 stat", -1, 32'(int_stat_o), 32'd0);
        check("R1 src", -1, 32'(src_eng_o), 32'd0);
        check("R1 dir", -1, 32'(src_dir_o), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: drive at the falling edge, check after the next rising edge.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ctrl_i       = TBL[i].ctrl;
            evt_valid_i  = TBL[i].ev;
            evt_src_i    = TBL[i].src;
            evt_dir_i    = TBL[i].dir;
            motion_en_i  = TBL[i].men;
            motion_act_i = TBL[i].mact;
            rel_rd_i     = TBL[i].rel;
            tick();
            check($sformatf("R%0d pin", TBL[i].req), i, 32'(int_pin_o), 32'(TBL[i].e_pin));
            check($sformatf("R%0d stat", TBL[i].req), i, 32'(int_stat_o), 32'(TBL[i].e_stat));
            check($sformatf("R%0d src", TBL[i].req), i, 32'(src_eng_o), 32'(TBL[i].e_src));
            check($sformatf("R%0d dir", TBL[i].req), i, 32'(src_dir_o), 32'(TBL[i].e_dir));
        end

        // R1: reset while an event is pending and a pulse is running
        @(negedge clk);
        ctrl_i = 4'hE; motion_en_i = 1'b0; motion_act_i = 1'b0;
        evt_valid_i = 1'b1; evt_src_i = 4'h5; evt_dir_i = 6'h11;
        tick();
        @(negedge clk);
        evt_valid_i = 1'b0; rst_n = 1'b0;
        tick();
        check("R1 pin after reset", 100, 32'(int_pin_o), 32'd0);
        check("R1 stat after reset", 100, 32'(int_stat_o), 32'd0);
        check("R1 src after reset", 100, 32'(src_eng_o), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: changing polarity alone flips the idle level at once
        ctrl_i = 4'hA;
        #1;
        check("R7 idle high", 101, 32'(int_pin_o), 32'd1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule